// File: doc/BRIEF.md
# Rollover Event and Interrupt Unit

This unit sits next to a time-of-day and calendar counter. The counter produces one-cycle strobes when its second, minute, half-day, day, day-of-week and month fields roll over. The unit turns each strobe into a sticky status flag, and it also takes a one-cycle pulse from the alarm comparator. The new-week strobe is expected when the day of week wraps from 7 back to 1. The half-day strobe only counts while the counter runs in 12-hour mode. In 24-hour mode that strobe is discarded.

Software reaches four registers through a small write/read port: status, enable, mask and set. Status bits are cleared by writing 1 to them. Enable and mask are plain read/write registers. A write of 1 to a set-register bit forces the matching status bit, so the interrupt path can be exercised without waiting for real time to pass. A single level interrupt line is high while any source is flagged, enabled and not masked.

Top module: `rollirq_top`

## Requirements
- R1: After reset the status, enable and mask registers read 0 and `irq` is low.
- R2: A strobe on a rollover input sets its status bit on the next clock edge. Bit positions are: second 0, minute 1, half-day 2, day 3, week 4, month 5.
- R3: While `mode12h` is 0 the half-day strobe is ignored and status bit 2 stays as it was.
- R4: A write to address 0 clears exactly the status bits written as 1. Other bits keep their value.
- R5: If a source's event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R6: A write to address 3 forces every status bit written as 1. Reads from address 3 return 0.
- R7: Address 1 (enable) and address 2 (mask) store the written value and read it back.
- R8: `irq` equals the OR over all bits of status AND enable AND NOT mask. It follows the registers with no added delay.
- R9: A pulse on `alarmHit` sets status bit 6 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode12h | input | 1 | 1 when the counter runs in 12-hour mode |
| secRoll | input | 1 | Seconds field rollover strobe |
| minRoll | input | 1 | Minutes field rollover strobe |
| halfDayRoll | input | 1 | Half-day (a.m./p.m.) rollover strobe |
| dayRoll | input | 1 | Day rollover strobe |
| weekRoll | input | 1 | Day-of-week wrap (7 to 1) strobe |
| monthRoll | input | 1 | Month rollover strobe |
| alarmHit | input | 1 | Alarm match pulse |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Write address: 0 status, 1 enable, 2 mask, 3 set |
| regWdata | input | 7 | Write data, one bit per source |
| rdAddr | input | 2 | Read address, same map as the write address |
| rdData | output | 7 | Combinational read data |
| irq | output | 1 | Level interrupt request |

## Verification
The collision that matters is a source's event strobe landing in the same cycle as a write-1-to-clear of the same status bit. Set writes and event strobes can also land together. The bench creates these cases on purpose with directed steps. It also lets random event strobes and random register writes overlap freely over several hundred cycles. A reference model in the bench applies clear first, then ORs in the events and forced bits. After every edge it checks the read-back value and `irq` against that model, so a design that lets the clear win is caught.

// File: rtl/rollirq_pkg.sv
package rollirq_pkg;
  localparam int SRC_W  = 7;
  localparam int ADDR_W = 2;

  localparam int SRC_SEC   = 0;
  localparam int SRC_MIN   = 1;
  localparam int SRC_HALF  = 2;
  localparam int SRC_DAY   = 3;
  localparam int SRC_WEEK  = 4;
  localparam int SRC_MONTH = 5;
  localparam int SRC_ALARM = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_MASK   = 2'd2,
    REG_SET    = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic             clrStatus;
    logic             setStatus;
    logic             wrEnable;
    logic             wrMask;
    logic [SRC_W-1:0] wdata;
  } regStrobe_t;
endpackage

// File: rtl/rollirq_ctrl.sv
module rollirq_ctrl
  import rollirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode12h,
  input  logic              secRoll,
  input  logic              minRoll,
  input  logic              halfDayRoll,
  input  logic              dayRoll,
  input  logic              weekRoll,
  input  logic              monthRoll,
  input  logic              alarmHit,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SRC_W-1:0]  regWdata,
  output regStrobe_t        strb,
  output logic [SRC_W-1:0]  evtVec
);
  regAddr_e addrDec;

  always_comb begin
    addrDec        = regAddr_e'(regAddr);
    strb.wdata     = regWdata;
    strb.clrStatus = regWr && (addrDec == REG_STATUS);
    strb.wrEnable  = regWr && (addrDec == REG_ENABLE);
    strb.wrMask    = regWr && (addrDec == REG_MASK);
    strb.setStatus = regWr && (addrDec == REG_SET);
  end

  always_comb begin
    evtVec            = '0;
    evtVec[SRC_SEC]   = secRoll;
    evtVec[SRC_MIN]   = minRoll;
    evtVec[SRC_HALF]  = halfDayRoll && mode12h;
    evtVec[SRC_DAY]   = dayRoll;
    evtVec[SRC_WEEK]  = weekRoll;
    evtVec[SRC_MONTH] = monthRoll;
    evtVec[SRC_ALARM] = alarmHit;
  end

  AST_HALF_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !mode12h |-> !evtVec[SRC_HALF]); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrStatus, strb.setStatus, strb.wrEnable, strb.wrMask})); // R7
endmodule

// File: rtl/rollirq_datapath.sv
module rollirq_datapath
  import rollirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [SRC_W-1:0]  evtVec,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [SRC_W-1:0]  rdData,
  output logic              irq
);
  logic [SRC_W-1:0] statusQ, enableQ, maskQ;
  logic [SRC_W-1:0] clrBits, setBits, statusD;

  always_comb begin
    clrBits = strb.clrStatus ? strb.wdata : '0;
    setBits = strb.setStatus ? strb.wdata : '0;
    statusD = (statusQ & ~clrBits) | evtVec | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusD;
      if (strb.wrEnable) enableQ <= strb.wdata;
      if (strb.wrMask)   maskQ   <= strb.wdata;
    end
  end

  always_comb begin
    unique case (regAddr_e'(rdAddr))
      REG_STATUS: rdData = statusQ;
      REG_ENABLE: rdData = enableQ;
      REG_MASK:   rdData = maskQ;
      default:    rdData = '0;
    endcase
  end

  assign irq = |(statusQ & enableQ & ~maskQ);

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    |evtVec |=> ((statusQ & $past(evtVec)) == $past(evtVec))); // R5
  AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStatus |=> ((statusQ & $past(strb.wdata)) == $past(strb.wdata))); // R6
  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(statusQ & ~clrBits)) == $past(statusQ & ~clrBits))); // R4
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irq); // R8
endmodule

// File: rtl/rollirq_top.sv
module rollirq_top
  import rollirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode12h,
  input  logic              secRoll,
  input  logic              minRoll,
  input  logic              halfDayRoll,
  input  logic              dayRoll,
  input  logic              weekRoll,
  input  logic              monthRoll,
  input  logic              alarmHit,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SRC_W-1:0]  regWdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [SRC_W-1:0]  rdData,
  output logic              irq
);
  regStrobe_t       strb;
  logic [SRC_W-1:0] evtVec;

  rollirq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .mode12h(mode12h),
    .secRoll(secRoll), .minRoll(minRoll), .halfDayRoll(halfDayRoll),
    .dayRoll(dayRoll), .weekRoll(weekRoll), .monthRoll(monthRoll),
    .alarmHit(alarmHit), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .evtVec(evtVec)
  );

  rollirq_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtVec(evtVec),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/tb_rollirq_top.sv
module tb_rollirq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode12h = 1'b0;
  logic [5:0] rolls = '0;
  logic alarmHit = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [6:0] regWdata = '0;
  logic [1:0] rdAddr = '0;
  logic [6:0] rdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [6:0] mStatus = '0, mEnable = '0, mMask = '0;

  always #2 clk = ~clk;

  rollirq_top dut (
    .clk(clk), .rstN(rstN), .mode12h(mode12h),
    .secRoll(rolls[0]), .minRoll(rolls[1]), .halfDayRoll(rolls[2]),
    .dayRoll(rolls[3]), .weekRoll(rolls[4]), .monthRoll(rolls[5]),
    .alarmHit(alarmHit), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [6:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mStatus;
      2'd1: return mEnable;
      2'd2: return mMask;
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic modelIrq();
    return |(mStatus & mEnable & ~mMask);
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, update model at posedge, sample 1 ns later.
  task automatic step(input string tag, input logic m12, input logic [5:0] r, input logic al,
                      input logic wr, input logic [1:0] wa, input logic [6:0] wd,
                      input logic [1:0] ra);
    logic [6:0] ev;
    @(negedge clk);
    mode12h = m12; rolls = r; alarmHit = al;
    regWr = wr; regAddr = wa; regWdata = wd; rdAddr = ra;
    @(posedge clk);
    ev = {al, r};
    if (!m12) ev[2] = 1'b0;
    mStatus = (mStatus & ~((wr && wa == 2'd0) ? wd : 7'd0)) | ev | ((wr && wa == 2'd3) ? wd : 7'd0);
    if (wr && wa == 2'd1) mEnable = wd;
    if (wr && wa == 2'd2) mMask = wd;
    #1;
    check(tag, rdData, modelRead(ra));
    check("R8", {6'd0, irq}, {6'd0, modelIrq()});
    @(negedge clk);
    rolls = '0; alarmHit = 1'b0; regWr = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    for (int a = 0; a < 4; a++) begin
      rdAddr = a[1:0]; #0.5;
      check("R1", rdData, 7'd0);
    end
    check("R1", {6'd0, irq}, 7'd0);
    @(negedge clk) rstN = 1'b1;

    // R2 each rollover source, 12-hour mode
    for (int b = 0; b < 6; b++) begin
      step("R2", 1'b1, 6'(1 << b), 1'b0, 1'b0, 2'd0, 7'd0, 2'd0);
      step("R4", 1'b1, 6'd0, 1'b0, 1'b1, 2'd0, 7'h7f, 2'd0);
    end
    // R3 half-day ignored in 24-hour mode
    step("R3", 1'b0, 6'b000100, 1'b0, 1'b0, 2'd0, 7'd0, 2'd0);
    check("R3", rdData, 7'd0);
    // R9 alarm
    step("R9", 1'b0, 6'd0, 1'b1, 1'b0, 2'd0, 7'd0, 2'd0);
    check("R9", rdData, 7'h40);
    // R7 enable and mask
    step("R7", 1'b0, 6'd0, 1'b0, 1'b1, 2'd1, 7'h55, 2'd1);
    step("R7", 1'b0, 6'd0, 1'b0, 1'b1, 2'd2, 7'h2a, 2'd2);
    // R6 set forces bits, address 3 reads zero
    step("R6", 1'b0, 6'd0, 1'b0, 1'b1, 2'd3, 7'h03, 2'd3);
    step("R6", 1'b0, 6'd0, 1'b0, 1'b0, 2'd0, 7'd0, 2'd0);
    check("R6", rdData, 7'h43);
    // R4 partial clear
    step("R4", 1'b0, 6'd0, 1'b0, 1'b1, 2'd0, 7'h01, 2'd0);
    check("R4", rdData, 7'h42);
    // R5 event and clear on same bit
    step("R5", 1'b0, 6'b000010, 1'b0, 1'b1, 2'd0, 7'h02, 2'd0);
    check("R5", rdData, 7'h42);
    // R8 full mask silences irq
    step("R8", 1'b0, 6'd0, 1'b0, 1'b1, 2'd2, 7'h7f, 2'd0);
    check("R8", {6'd0, irq}, 7'd0);
    step("R8", 1'b0, 6'd0, 1'b0, 1'b1, 2'd2, 7'h00, 2'd0);
    check("R8", {6'd0, irq}, 7'd1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] r;
      for (int b = 0; b < 6; b++) r[b] = ($urandom % 8) == 0;
      step("R2", 1'($urandom), r, ($urandom % 10) == 0, ($urandom % 3) == 0,
           2'($urandom), 7'($urandom), 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule